// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

This block watches a byte-wide receive stream in which each frame begins with the first destination address byte and ends with the last CRC byte. It decides for each frame whether the frame is accepted, based on an exact match against one programmed station address, broadcast rejection, promiscuous mode, and an optional rule that drops frames arriving while the local transmitter is busy. It also measures each frame's length against a programmable maximum and flags frames that are too long.

One cycle after the last byte of a frame, the block issues a status strobe. With that strobe it reports accept or reject, a miss flag, a long-frame flag and a one-cycle babble interrupt. The maximum length sits in a small register that a write strobe loads and reset sets to 1518. The other configuration inputs are meant to stay static while the block is enabled. A combinational error output flags the illegal pairing of internal loopback with the transmit-time receive block.

Top module: `rx_frame_filter`

## Requirements
- R1: The maximum-length setting is 11 bits wide and is 1518 after reset. On a clock edge where `max_len_we` is high, it loads `max_len_wdata`.
- R2: Frame length counts every byte from the first destination address byte through the last byte (the byte with `rx_last`). A frame whose length is strictly greater than the maximum sets `stat_long` and pulses `babble_irq` together with its status. A frame whose length equals the maximum sets neither.
- R3: The length counter saturates at 2047, and any frame longer than 2047 bytes is always reported long.
- R4: The first received byte is compared with `cfg_station_addr[47:40]` and the sixth with `[7:0]`. Outside promiscuous mode, a non-broadcast frame is accepted with `stat_miss`=0 only when all six bytes match, and is rejected otherwise.
- R5: A broadcast frame (destination FF_FF_FF_FF_FF_FF) is accepted with miss 0 when `cfg_bcast_reject` is 0. It is rejected when `cfg_bcast_reject` is 1 and `cfg_promisc` is 0.
- R6: With `cfg_bcast_reject` and `cfg_promisc` both 1, a broadcast frame is accepted with `stat_miss`=1.
- R7: In promiscuous mode every frame of at least 6 bytes is accepted. `stat_miss` is 1 for a non-broadcast destination that differs from the station address and 0 for one that matches.
- R8: When `cfg_rx_off_on_tx` is 1 and `tx_busy` is high on the cycle of a frame's first byte, the frame is discarded: its status has accept, miss and long all 0 and there is no interrupt. `tx_busy` rising after the first byte, or `tx_busy` with `cfg_rx_off_on_tx`=0, has no effect.
- R9: A frame shorter than 6 bytes is rejected with miss 0.
- R10: `stat_valid` is high for exactly one cycle, on the cycle after the last byte, and is never high during a frame. `stat_accept`, `stat_miss`, `stat_long` and `babble_irq` are 0 whenever `stat_valid` is 0.
- R11: `cfg_error` is high exactly when `cfg_loopback` and `cfg_rx_off_on_tx` are both 1.
- R12: While `enable` is low, bytes are ignored and no status is produced. A frame cut off by `enable` going low produces no status, and the next byte after re-enable starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Filter enable |
| max_len_we | input | 1 | Load strobe for the maximum length |
| max_len_wdata | input | 11 | New maximum length |
| cfg_station_addr | input | 48 | Station address, first byte in bits 47:40 |
| cfg_bcast_reject | input | 1 | Reject broadcast destinations |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_rx_off_on_tx | input | 1 | Drop frames that start while transmitting |
| cfg_loopback | input | 1 | Internal loopback selected (checked only) |
| tx_busy | input | 1 | Local transmitter active |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Byte is the last of the frame |
| stat_valid | output | 1 | End-of-frame status strobe |
| stat_accept | output | 1 | Frame accepted |
| stat_miss | output | 1 | Accepted without address match |
| stat_long | output | 1 | Frame exceeded maximum length |
| babble_irq | output | 1 | Babble receive interrupt pulse |
| cfg_error | output | 1 | Illegal configuration pairing |

## Verification
The bench builds the block with its default parameters: an 11-bit length field and a 6-byte address. This keeps the 2047-byte saturation point within a few thousand cycles, so frames of 2047 and 2049 bytes can be driven in full. The reset maximum of 1518 is probed with 1518- and 1519-byte frames. A rewritten maximum of 64 then makes the equal-versus-one-over boundary cheap to test against every address mode.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef struct packed {
    logic accept;
    logic miss;
  } rxf_verdict_t;

  // Per-frame accept/miss decision from the collected frame facts.
  function automatic rxf_verdict_t rxf_decide(
    input logic blocked,
    input logic too_short,
    input logic is_bcast,
    input logic addr_hit,
    input logic bc_rej,
    input logic promisc
  );
    rxf_verdict_t v;
    v = '0;
    if (blocked || too_short) begin
      v = '0;
    end else if (is_bcast) begin
      v.accept = promisc | ~bc_rej;
      v.miss   = promisc & bc_rej;
    end else if (addr_hit) begin
      v.accept = 1'b1;
    end else if (promisc) begin
      v.accept = 1'b1;
      v.miss   = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/rxf_maxlen_reg.sv
module rxf_maxlen_reg #(
  parameter int LEN_W     = 11,
  parameter int RESET_LEN = 1518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LEN_W-1:0] wdata,
  output logic [LEN_W-1:0] q
);
  localparam logic [LEN_W-1:0] RST_V = LEN_W'(RESET_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= RST_V;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/rxf_len_counter.sv
module rxf_len_counter #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             first,
  input  logic [LEN_W-1:0] max_len,
  output logic [LEN_W-1:0] byte_idx,
  output logic [LEN_W-1:0] cnt_next,
  output logic             long_next,
  output logic [LEN_W-1:0] cnt_q
);
  localparam logic [LEN_W-1:0] CAP = {LEN_W{1'b1}};

  logic ovf_q, ovf_next;

  // Saturating increment: holds at CAP once reached.
  function automatic logic [LEN_W-1:0] sat_inc(input logic [LEN_W-1:0] v);
    return (v == CAP) ? CAP : v + 1'b1;
  endfunction

  always_comb begin
    byte_idx  = first ? '0 : cnt_q;
    cnt_next  = sat_inc(byte_idx);
    ovf_next  = (first ? 1'b0 : ovf_q) | (byte_idx == CAP);
    long_next = ovf_next | (cnt_next > max_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clear) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (take) begin
      cnt_q <= cnt_next;
      ovf_q <= ovf_next;
    end
  end
endmodule

// File: rtl/rxf_addr_match.sv
module rxf_addr_match #(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    first,
  input  logic                    in_da,
  input  logic [IDX_W-1:0]        lane,
  input  logic [7:0]              data,
  input  logic [8*ADDR_BYTES-1:0] station,
  output logic                    hit_next,
  output logic                    bcast_next
);
  localparam int LANES = 1 << IDX_W;

  logic [LANES-1:0] lane_eq;
  logic hit_q, bcast_q, cur_eq, cur_ff;

  // One comparator per address byte; unused lanes compare true.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i < ADDR_BYTES) begin : g_used
      assign lane_eq[i] = (data == station[8*(ADDR_BYTES-1-i) +: 8]);
    end else begin : g_pad
      assign lane_eq[i] = 1'b1;
    end
  end

  always_comb begin
    cur_eq     = ~in_da | lane_eq[lane];
    cur_ff     = ~in_da | (data == 8'hFF);
    hit_next   = (first ? 1'b1 : hit_q) & cur_eq;
    bcast_next = (first ? 1'b1 : bcast_q) & cur_ff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      bcast_q <= 1'b0;
    end else if (take) begin
      hit_q   <= hit_next;
      bcast_q <= bcast_next;
    end
  end
endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rxf_pkg::*;
#(
  parameter int LEN_W      = 11,
  parameter int ADDR_BYTES = 6,
  parameter int RESET_LEN  = 1518
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    max_len_we,
  input  logic [LEN_W-1:0]        max_len_wdata,
  input  logic [8*ADDR_BYTES-1:0] cfg_station_addr,
  input  logic                    cfg_bcast_reject,
  input  logic                    cfg_promisc,
  input  logic                    cfg_rx_off_on_tx,
  input  logic                    cfg_loopback,
  input  logic                    tx_busy,
  input  logic                    rx_valid,
  input  logic [7:0]              rx_data,
  input  logic                    rx_last,
  output logic                    stat_valid,
  output logic                    stat_accept,
  output logic                    stat_miss,
  output logic                    stat_long,
  output logic                    babble_irq,
  output logic                    cfg_error
);
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam logic [LEN_W-1:0] DA_LEN = LEN_W'(ADDR_BYTES);

  // Named internal events, visible to the bound checker.
  logic             evt_take, evt_first, evt_end;
  logic             in_frame_q, blk_q, blk_next;
  logic [LEN_W-1:0] max_len, byte_idx, cnt_next, cnt_q;
  logic             long_next, in_da, hit_next, bcast_next, too_short;
  rxf_verdict_t     verdict;

  assign evt_take  = enable & rx_valid;
  assign evt_first = evt_take & ~in_frame_q;
  assign evt_end   = evt_take & rx_last;
  assign blk_next  = evt_first ? (cfg_rx_off_on_tx & tx_busy) : blk_q;
  assign in_da     = byte_idx < DA_LEN;
  assign too_short = cnt_next < DA_LEN;
  assign cfg_error = cfg_loopback & cfg_rx_off_on_tx;

  rxf_maxlen_reg #(.LEN_W(LEN_W), .RESET_LEN(RESET_LEN)) u_maxlen (
    .clk(clk), .rst_n(rst_n), .we(max_len_we), .wdata(max_len_wdata), .q(max_len)
  );

  rxf_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .clear(~enable), .take(evt_take), .first(evt_first),
    .max_len(max_len), .byte_idx(byte_idx), .cnt_next(cnt_next),
    .long_next(long_next), .cnt_q(cnt_q)
  );

  rxf_addr_match #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .take(evt_take), .first(evt_first), .in_da(in_da),
    .lane(byte_idx[IDX_W-1:0]), .data(rx_data), .station(cfg_station_addr),
    .hit_next(hit_next), .bcast_next(bcast_next)
  );

  assign verdict = rxf_decide(blk_next, too_short, bcast_next, hit_next,
                              cfg_bcast_reject, cfg_promisc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      blk_q      <= 1'b0;
    end else if (!enable) begin
      in_frame_q <= 1'b0;
      blk_q      <= 1'b0;
    end else if (evt_take) begin
      in_frame_q <= ~rx_last;
      blk_q      <= blk_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid  <= 1'b0;
      stat_accept <= 1'b0;
      stat_miss   <= 1'b0;
      stat_long   <= 1'b0;
      babble_irq  <= 1'b0;
    end else begin
      stat_valid  <= evt_end;
      stat_accept <= evt_end & verdict.accept;
      stat_miss   <= evt_end & verdict.miss;
      stat_long   <= evt_end & long_next & ~blk_next;
      babble_irq  <= evt_end & long_next & ~blk_next;
    end
  end
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             rx_valid,
  input logic             rx_last,
  input logic             in_frame_q,
  input logic [LEN_W-1:0] cnt_q,
  input logic             cfg_loopback,
  input logic             cfg_rx_off_on_tx,
  input logic             cfg_error,
  input logic             stat_valid,
  input logic             stat_accept,
  input logic             stat_miss,
  input logic             stat_long,
  input logic             babble_irq
);
  // R10
  strobe_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(enable && rx_valid && rx_last));

  // R10
  flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_valid |-> !(stat_accept || stat_miss || stat_long || babble_irq));

  // R6
  miss_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_miss |-> stat_accept);

  // R2
  irq_with_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
    babble_irq == stat_long);

  // R11
  cfg_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error == (cfg_loopback && cfg_rx_off_on_tx));

  // R12
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !in_frame_q && cnt_q == '0 && !stat_valid);
endmodule

bind rx_frame_filter rxf_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .rx_valid(rx_valid), .rx_last(rx_last),
  .in_frame_q(in_frame_q), .cnt_q(cnt_q), .cfg_loopback(cfg_loopback),
  .cfg_rx_off_on_tx(cfg_rx_off_on_tx), .cfg_error(cfg_error),
  .stat_valid(stat_valid), .stat_accept(stat_accept), .stat_miss(stat_miss),
  .stat_long(stat_long), .babble_irq(babble_irq)
);

// File: tb/sim_rx_frame_filter.sv
module sim_rx_frame_filter;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] STATION = 48'h02_1A_2B_3C_4D_5E;
  localparam logic [47:0] BCAST   = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] OTHER   = 48'h02_1A_2B_3C_4D_5F;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic max_len_we = 1'b0;
  logic [10:0] max_len_wdata = '0;
  logic bc_rej = 1'b0, promisc = 1'b0, rx_off = 1'b0, loopback = 1'b0, tx_busy = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_data = '0;
  logic stat_valid, stat_accept, stat_miss, stat_long, babble_irq, cfg_error;

  int checks = 0, fails = 0, pulses = 0, cur_max = 1518;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (stat_valid) pulses <= pulses + 1;

  rx_frame_filter u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .max_len_we(max_len_we),
    .max_len_wdata(max_len_wdata), .cfg_station_addr(STATION),
    .cfg_bcast_reject(bc_rej), .cfg_promisc(promisc), .cfg_rx_off_on_tx(rx_off),
    .cfg_loopback(loopback), .tx_busy(tx_busy), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last), .stat_valid(stat_valid),
    .stat_accept(stat_accept), .stat_miss(stat_miss), .stat_long(stat_long),
    .babble_irq(babble_irq), .cfg_error(cfg_error)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_max(input int v);
    max_len_wdata = 11'(v); max_len_we = 1'b1;
    @(negedge clk); max_len_we = 1'b0; cur_max = v;
  endtask

  // Drives one frame from a negedge; returns having sampled the status strobe.
  task automatic send(input logic [47:0] da, input int len, input bit busy_first,
                      input bit busy_mid, output bit sv, output bit a,
                      output bit m, output bit l, output bit irq);
    int p0 = pulses;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1;
      rx_data  = (i < 6) ? da[8*(5-i) +: 8] : 8'(i & 8'h7F);
      rx_last  = (i == len - 1);
      tx_busy  = (i == 0) ? busy_first : (busy_mid && i >= 2);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_last = 1'b0; tx_busy = 1'b0;
    sv = stat_valid; a = stat_accept; m = stat_miss; l = stat_long; irq = babble_irq;
    check("R10 no strobe inside frame", pulses - p0, 0);
    @(negedge clk);
    check("R10 strobe lasts one cycle", pulses - p0, 1);
    check("R10 strobe low after", int'(stat_valid), 0);
  endtask

  // Independent expectation from the requirement text.
  task automatic frame(input string req, input logic [47:0] da, input int len,
                       input bit busy_first, input bit busy_mid);
    bit sv, a, m, l, irq, dropped, ea, em, el;
    send(da, len, busy_first, busy_mid, sv, a, m, l, irq);
    dropped = rx_off && busy_first;
    el = !dropped && (len > cur_max);
    case (1'b1)
      dropped, (len < 6): begin ea = 0; em = 0; end
      promisc:            begin ea = 1; em = (da == BCAST) ? bc_rej : (da != STATION); end
      (da == BCAST):      begin ea = !bc_rej; em = 0; end
      default:            begin ea = (da == STATION); em = 0; end
    endcase
    check({req, " valid"}, int'(sv), 1);
    check({req, " accept"}, int'(a), int'(ea));
    check({req, " miss"}, int'(m), int'(em));
    check({req, " long"}, int'(l), int'(el));
    check({req, " babble"}, int'(irq), int'(el));
  endtask

  task automatic t_reset;
    check("R10 reset stat_valid", int'(stat_valid), 0);
    check("R11 reset cfg_error", int'(cfg_error), 0);
    frame("R1 default max 1518 equal", STATION, 1518, 0, 0);
    frame("R1 default max 1519 over", STATION, 1519, 0, 0);
  endtask

  task automatic t_length;
    set_max(64);
    frame("R2 length equal max", STATION, 64, 0, 0);
    frame("R2 length one over", STATION, 65, 0, 0);
    frame("R2 long on rejected frame", OTHER, 100, 0, 0);
    set_max(2047);
    frame("R3 2047 bytes not long", STATION, 2047, 0, 0);
    frame("R3 2049 bytes saturates long", STATION, 2049, 0, 0);
    set_max(64);
  endtask

  task automatic t_address;
    frame("R4 exact match", STATION, 20, 0, 0);
    frame("R4 last byte differs", OTHER, 20, 0, 0);
    frame("R4 first byte differs", 48'h82_1A_2B_3C_4D_5E, 20, 0, 0);
    frame("R5 broadcast allowed", BCAST, 20, 0, 0);
    bc_rej = 1'b1;
    frame("R5 broadcast rejected", BCAST, 20, 0, 0);
    frame("R5 near broadcast is unicast", 48'hFFFF_FFFF_FFFE, 20, 0, 0);
    promisc = 1'b1;
    frame("R6 broadcast in promisc with reject", BCAST, 20, 0, 0);
    bc_rej = 1'b0;
    frame("R7 promisc mismatch", OTHER, 20, 0, 0);
    frame("R7 promisc match", STATION, 20, 0, 0);
    frame("R7 promisc broadcast", BCAST, 20, 0, 0);
    promisc = 1'b0;
  endtask

  task automatic t_short;
    frame("R9 five byte frame", STATION, 5, 0, 0);
    frame("R9 one byte frame", STATION, 1, 0, 0);
    promisc = 1'b1;
    frame("R9 short in promisc", OTHER, 3, 0, 0);
    promisc = 1'b0;
    frame("R9 six byte frame", STATION, 6, 0, 0);
  endtask

  task automatic t_txblock;
    rx_off = 1'b1;
    frame("R8 dropped while transmitting", STATION, 100, 1, 0);
    frame("R8 busy after start ignored", STATION, 20, 0, 1);
    rx_off = 1'b0;
    frame("R8 busy ignored when disabled", STATION, 100, 1, 1);
  endtask

  task automatic t_cfg_error;
    loopback = 1'b1; #1;
    check("R11 loopback alone", int'(cfg_error), 0);
    rx_off = 1'b1; #1;
    check("R11 both set", int'(cfg_error), 1);
    loopback = 1'b0; rx_off = 1'b0; #1;
    check("R11 cleared", int'(cfg_error), 0);
    @(negedge clk);
  endtask

  task automatic t_enable;
    int p0;
    p0 = pulses;
    rx_valid = 1'b1; rx_data = 8'h02; rx_last = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    rx_data = 8'h11; rx_last = 1'b1;
    repeat (3) @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    @(negedge clk);
    check("R12 no status while disabled", pulses - p0, 0);
    enable = 1'b1;
    frame("R12 fresh frame after re-enable", STATION, 12, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    t_reset;
    t_length;
    t_address;
    t_short;
    t_txblock;
    t_cfg_error;
    t_enable;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule